// File: doc/BRIEF.md
# Multi-Rate Clock-Enable Generator

This block lets a whole subsystem run on one fast master clock without a tree of divided or gated clocks. For each configured integer ratio N it produces a strobe that is high for one master cycle out of every N. Downstream flops stay on the master clock and use the strobe as a clock enable. No derived clock ever drives a flop.

The block also accepts a small number of clock signals from outside the master domain. Each one passes through a three-stage synchroniser clocked by the master, where the first stage only absorbs metastability. The last two stages are compared to make one-cycle rising-edge and falling-edge enables. Logic that used to be clocked by a foreign clock can then sample its data on the master clock, qualified by the rising-edge enable.

Ratios are given as a packed list of 8-bit fields, and the number of external inputs is a parameter. A synchronous reset clears every counter and synchroniser stage together, so all strobes restart in a common phase.

Top module: `rate_strobe_gen`

## Requirements
- R1: While reset is sampled high at a clock edge, every output (`rate_en`, `ext_rise`, `ext_fall`) is 0 after that edge, and all synchroniser stages are cleared to 0.
- R2: Take the edges after reset release and number the first one 1. Strobe i, with ratio N taken from field i (bits 8i+7..8i of `div_list`), is high after edges N, 2N, 3N and so on, and low after every other edge. All strobes share this origin.
- R3: For N of 2 or more, each strobe pulse lasts exactly one master cycle. For N equal to 1, the strobe is high in every cycle after reset release.
- R4: Suppose an external input is sampled high at edge k and was sampled low at edge k-1 (or edge k-1 fell in reset). Then its `ext_rise` bit is high for exactly the one cycle after edge k+1.
- R5: Suppose an external input is sampled low at edge k and was sampled high at edge k-1. Then its `ext_fall` bit is high for exactly the one cycle after edge k+1.
- R6: Over any stretch of stimulus, each external input gives exactly one `ext_rise` pulse per low-to-high change of its sampled level. This holds even when the input toggles on every master cycle. `ext_rise` and `ext_fall` of the same input are never high together.
- R7: Asserting reset in the middle of operation restarts every strobe on the R2 schedule, counted from the new release.
- R8: An external input that is held high through reset gives one `ext_rise` pulse after release, because the synchroniser starts from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mst | input | 1 | Master clock; every register uses it |
| rst_sync | input | 1 | Synchronous reset, active high |
| ext_clk_in | input | NUM_EXT | Asynchronous external clock signals |
| rate_en | output | NUM_DIV | One-cycle enable strobes, one per configured ratio |
| ext_rise | output | NUM_EXT | One-cycle enable per rising edge of each external input |
| ext_fall | output | NUM_EXT | One-cycle enable per falling edge of each external input |

## Verification
The bench compares every output, on every master cycle, against a behavioural model built from a running cycle count since release and the last three sampled levels of each input.

The external inputs receive three different patterns at once:
- a toggle on every master cycle, which shows whether back-to-back edges merge or get lost;
- an irregular duty pattern, which separates edge detection from level detection;
- a slow square wave, which exposes extra pulses on long flat stretches.

An input held high through reset checks that the synchroniser is cleared. A reset in mid-run, at a cycle that is not a multiple of any ratio, shows whether the dividers re-align or keep their old phase.

// File: rtl/cen_pkg.sv
package cen_pkg;
   localparam int RATIO_W = 8;
   typedef logic [RATIO_W-1:0] ratio_t;

   function automatic int cnt_width(input int ratio);
      return (ratio > 2) ? $clog2(ratio) : 1;
   endfunction
endpackage

// File: rtl/cen_div.sv
module cen_div import cen_pkg::*; #(
   parameter int RATIO = 2
) (
   input  logic clk_mst,
   input  logic rst_sync,
   output logic strobe
);
   localparam int CW = cnt_width(RATIO);

   initial begin
      if (RATIO < 1 || RATIO > (1 << RATIO_W) - 1)
         $fatal(1, "cen_div: RATIO %0d out of range", RATIO);
   end

   generate
      if (RATIO == 1) begin : g_pass
         always_ff @(posedge clk_mst) begin
            strobe <= !rst_sync;
         end
      end else if (RATIO == 2) begin : g_toggle
         logic phase;
         always_ff @(posedge clk_mst) begin
            if (rst_sync) begin
               phase  <= 1'b0;
               strobe <= 1'b0;
            end else begin
               phase  <= ~phase;
               strobe <= phase;
            end
         end
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk_mst) begin
            if (rst_sync) begin
               cnt    <= '0;
               strobe <= 1'b0;
            end else begin
               strobe <= (cnt == LAST);
               cnt    <= (cnt == LAST) ? '0 : cnt + CW'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cen_edge_sync.sv
module cen_edge_sync (
   input  logic clk_mst,
   input  logic rst_sync,
   input  logic async_in,
   output logic rise_en,
   output logic fall_en
);
   logic meta_q;
   logic lvl_q;
   logic lvl_d1_q;
   logic changed;

   always_ff @(posedge clk_mst) begin
      if (rst_sync) begin
         meta_q   <= 1'b0;
         lvl_q    <= 1'b0;
         lvl_d1_q <= 1'b0;
      end else begin
         meta_q   <= async_in;
         lvl_q    <= meta_q;
         lvl_d1_q <= lvl_q;
      end
   end

   assign changed = lvl_q ^ lvl_d1_q;
   assign rise_en = changed & lvl_q;
   assign fall_en = changed & ~lvl_q;
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen import cen_pkg::*; #(
   parameter int NUM_DIV = 8,
   parameter int NUM_EXT = 3,
   parameter logic [NUM_DIV*RATIO_W-1:0] DIV_LIST =
      {8'd144, 8'd72, 8'd18, 8'd8, 8'd4, 8'd3, 8'd2, 8'd1}
) (
   input  logic               clk_mst,
   input  logic               rst_sync,
   input  logic [NUM_EXT-1:0] ext_clk_in,
   output logic [NUM_DIV-1:0] rate_en,
   output logic [NUM_EXT-1:0] ext_rise,
   output logic [NUM_EXT-1:0] ext_fall
);
   initial begin
      if (NUM_DIV < 1) $fatal(1, "rate_strobe_gen: NUM_DIV must be at least 1");
      if (NUM_EXT < 1) $fatal(1, "rate_strobe_gen: NUM_EXT must be at least 1");
   end

   generate
      for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
         localparam int R = int'(DIV_LIST[i*RATIO_W +: RATIO_W]);
         cen_div #(.RATIO(R)) u_div (
            .clk_mst (clk_mst),
            .rst_sync(rst_sync),
            .strobe  (rate_en[i])
         );
      end

      for (genvar j = 0; j < NUM_EXT; j++) begin : g_ext
         cen_edge_sync u_sync (
            .clk_mst (clk_mst),
            .rst_sync(rst_sync),
            .async_in(ext_clk_in[j]),
            .rise_en (ext_rise[j]),
            .fall_en (ext_fall[j])
         );
      end
   endgenerate
endmodule

// File: rtl/rate_strobe_gen_chk.sv
module rate_strobe_gen_chk import cen_pkg::*; #(
   parameter int NUM_DIV = 8,
   parameter int NUM_EXT = 3,
   parameter logic [NUM_DIV*RATIO_W-1:0] DIV_LIST = '0
) (
   input logic               clk_mst,
   input logic               rst_sync,
   input logic [NUM_EXT-1:0] ext_clk_in,
   input logic [NUM_DIV-1:0] rate_en,
   input logic [NUM_EXT-1:0] ext_rise,
   input logic [NUM_EXT-1:0] ext_fall
);
   // R1
   reset_clears_chk: assert property (@(posedge clk_mst)
      rst_sync |=> (rate_en == '0 && ext_rise == '0 && ext_fall == '0));

   generate
      for (genvar i = 0; i < NUM_DIV; i++) begin : g_d
         localparam int R = int'(DIV_LIST[i*RATIO_W +: RATIO_W]);
         logic [15:0] gap;
         always_ff @(posedge clk_mst) begin
            if (rst_sync)        gap <= '0;
            else if (rate_en[i]) gap <= 16'd1;
            else                 gap <= gap + 16'd1;
         end
         // R2 R7
         strobe_period_chk: assert property (@(posedge clk_mst) disable iff (rst_sync)
            rate_en[i] |-> (gap == 16'(R)));
         if (R > 1) begin : g_w
            // R3
            strobe_width_chk: assert property (@(posedge clk_mst) disable iff (rst_sync)
               rate_en[i] |=> !rate_en[i]);
         end
      end

      for (genvar j = 0; j < NUM_EXT; j++) begin : g_e
         // R4
         rise_source_chk: assert property (@(posedge clk_mst) disable iff (rst_sync)
            ext_rise[j] |-> $past(ext_clk_in[j], 2));
         // R4
         rise_width_chk: assert property (@(posedge clk_mst) disable iff (rst_sync)
            ext_rise[j] |=> !ext_rise[j]);
         // R5
         fall_source_chk: assert property (@(posedge clk_mst) disable iff (rst_sync)
            ext_fall[j] |-> !$past(ext_clk_in[j], 2));
         // R6
         edge_excl_chk: assert property (@(posedge clk_mst) disable iff (rst_sync)
            !(ext_rise[j] && ext_fall[j]));
      end
   endgenerate
endmodule

bind rate_strobe_gen rate_strobe_gen_chk #(
   .NUM_DIV (NUM_DIV),
   .NUM_EXT (NUM_EXT),
   .DIV_LIST(DIV_LIST)
) u_chk (.*);

// File: tb/rate_strobe_gen_tb.sv
module rate_strobe_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ND = 8;
   localparam int NE = 3;
   localparam int RAT [ND] = '{1, 2, 3, 4, 8, 18, 72, 144};
   localparam logic [ND*8-1:0] LIST =
      {8'd144, 8'd72, 8'd18, 8'd8, 8'd4, 8'd3, 8'd2, 8'd1};

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NE-1:0] ext = '0;
   logic [ND-1:0] rate_en;
   logic [NE-1:0] ext_rise;
   logic [NE-1:0] ext_fall;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rate_strobe_gen #(.NUM_DIV(ND), .NUM_EXT(NE), .DIV_LIST(LIST)) u_dut (
      .clk_mst   (clk),
      .rst_sync  (rst),
      .ext_clk_in(ext),
      .rate_en   (rate_en),
      .ext_rise  (ext_rise),
      .ext_fall  (ext_fall)
   );

   // behavioural reference: edges since release and last three samples
   int       since_rel = 0;
   bit       started   = 0;
   bit       in_mid    = 0;
   bit [2:0] hist [NE];
   int       obs_rise [NE];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      started <= 1'b1;
      if (rst) begin
         since_rel <= 0;
         for (int j = 0; j < NE; j++) hist[j] <= 3'b000;
      end else begin
         since_rel <= since_rel + 1;
         for (int j = 0; j < NE; j++) hist[j] <= {hist[j][1:0], ext[j]};
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         for (int i = 0; i < ND; i++) begin
            bit e;
            e = (since_rel > 0) && (since_rel % RAT[i] == 0);
            check(rate_en[i] == e,
                  (since_rel == 0) ? "R1" : (in_mid ? "R7" : "R2 R3"),
                  int'(rate_en[i]), int'(e));
         end
         for (int j = 0; j < NE; j++) begin
            bit er, ef;
            er = hist[j][1] & ~hist[j][2];
            ef = ~hist[j][1] & hist[j][2];
            check(ext_rise[j] == er, (since_rel == 0) ? "R1" : "R4",
                  int'(ext_rise[j]), int'(er));
            check(ext_fall[j] == ef, (since_rel == 0) ? "R1" : "R5",
                  int'(ext_fall[j]), int'(ef));
            check(!(ext_rise[j] && ext_fall[j]), "R6",
                  int'(ext_rise[j] & ext_fall[j]), 0);
            if (ext_rise[j]) obs_rise[j]++;
         end
      end
   end

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #2;
      end
   endtask

   function automatic logic [NE-1:0] pattern(input int c, input int variant);
      logic [NE-1:0] v;
      v[0] = (c % 2) == 1;
      v[1] = ((c * 7 + 3 + variant) % 11) < 5;
      v[2] = ((c / (7 + variant)) % 2) == 1;
      return v;
   endfunction

   initial begin
      int drv_rise [NE];
      int base [NE];
      for (int j = 0; j < NE; j++) obs_rise[j] = 0;

      // reset with inputs low, then release
      rst = 1'b1; ext = '0;
      step(4);
      rst = 1'b0;

      // three simultaneous patterns, counting driven rising edges
      for (int j = 0; j < NE; j++) begin
         drv_rise[j] = 0;
         base[j] = obs_rise[j];
      end
      for (int c = 0; c < 600; c++) begin
         logic [NE-1:0] nv;
         nv = pattern(c, 0);
         for (int j = 0; j < NE; j++) if (nv[j] && !ext[j]) drv_rise[j]++;
         ext = nv;
         step(1);
      end
      ext = '0;
      step(6);
      for (int j = 0; j < NE; j++)
         check(obs_rise[j] - base[j] == drv_rise[j], "R6",
               obs_rise[j] - base[j], drv_rise[j]);

      // inputs held high through reset
      ext = '1;
      rst = 1'b1;
      step(3);
      rst = 1'b0;
      for (int j = 0; j < NE; j++) base[j] = obs_rise[j];
      step(10);
      for (int j = 0; j < NE; j++)
         check(obs_rise[j] - base[j] == 1, "R8", obs_rise[j] - base[j], 1);
      step(27);

      // mid-run reset at an unaligned point, then realignment
      rst = 1'b1;
      step(2);
      rst = 1'b0;
      in_mid = 1'b1;
      for (int c = 0; c < 320; c++) begin
         ext = pattern(c, 2);
         step(1);
      end
      step(4);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule